// File: doc/BRIEF.md
# Station Pair Window Matcher

The matcher takes one set of trigger primitives from each of two detector stations per bunch crossing. Station A is the key station. Every primitive carries a valid tag, a 12-bit azimuth and an 8-bit polar angle. Each key primitive is paired with every partner primitive of station B.

A pair qualifies when all of the following hold:
- The pairing is geometrically allowed.
- Both primitives are valid.
- The absolute azimuth difference lies inside a programmable window.
- The absolute polar difference lies inside a second, independent window.

Among the qualifying partners, the one with the smallest azimuth difference is taken for that key. The block then reports three values per key:
- a match flag,
- the partner index,
- the azimuth difference.

The result set is registered, so it appears one clock after the input set. A downstream track assembler reads one result set per bunch crossing.

Top module: `station_pair_matcher`

## Requirements
- R1: A pair passes the azimuth test only if |phi_A − phi_B| is strictly less than `win_phi_i`. A difference equal to the window fails.
- R2: A pair passes the polar test only if |theta_A − theta_B| is strictly less than `win_theta_i`. A difference equal to the window fails.
- R3: For each key, the reported partner is the one with the smallest azimuth difference among partners that pass every test. A closer partner that fails the polar test is never chosen.
- R4: When two passing partners have the same azimuth difference, the lower partner index is reported.
- R5: A pair is compared only if bit `k*N_PART+p` of `ALLOW_MASK` is set. A masked pair is never matched, however small its differences are. By default, pair (k,p) is allowed when |k−p| ≤ 6.
- R6: A key or partner whose valid bit is 0 never takes part in a match.
- R7: A key with no passing partner reports match=0, with index 0 and difference 0.
- R8: Results are registered. Outputs change one rising clock edge after the inputs they are derived from, and they hold until the next edge. While `rst_ni` is low, all outputs are 0.
- R9: All 18 key primitives are resolved independently within the same cycle, each against all 18 partners. Key k's fields sit at `match_o[k]`, `idx_o[k*5 +: 5]` and `dphi_o[k*12 +: 12]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_vld_i | input | 18 | Valid tags, key station |
| a_phi_i | input | 216 | Key azimuths, 12 bits each, key k at [k*12 +: 12] |
| a_theta_i | input | 144 | Key polar angles, 8 bits each |
| b_vld_i | input | 18 | Valid tags, partner station |
| b_phi_i | input | 216 | Partner azimuths, 12 bits each |
| b_theta_i | input | 144 | Partner polar angles, 8 bits each |
| win_phi_i | input | 12 | Azimuth window (exclusive bound) |
| win_theta_i | input | 8 | Polar window (exclusive bound) |
| match_o | output | 18 | Match flag per key |
| idx_o | output | 90 | Chosen partner index per key, 5 bits each |
| dphi_o | output | 216 | Absolute azimuth difference per key, 12 bits each |

## Verification
The polar test and the minimum-azimuth selection meet in one cycle whenever the nearest partner in azimuth fails the polar window while a farther one passes. The bench sets this up directly and checks that the farther partner is reported. Mask rejection and selection also collide when an excluded partner sits closer in azimuth than an allowed one; the allowed one must win. Randomised sets with narrow value ranges make both cases frequent. Each result is judged against a bench model that scans the partners in index order.

// File: rtl/pair_match_pkg.sv
package pair_match_pkg;
  localparam int MASK_MAX = 1024;

  // allowed pair when key and partner index differ by at most span
  function automatic logic [MASK_MAX-1:0] band_mask(input int nk, input int np, input int span);
    logic [MASK_MAX-1:0] m;
    m = '0;
    for (int k = 0; k < nk; k++)
      for (int p = 0; p < np; p++)
        if ((k - p) <= span && (p - k) <= span) m[k*np+p] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pair_window_cell.sv
module pair_window_cell #(
  parameter int PHI_W = 12,
  parameter int TH_W  = 8
) (
  input  logic             allow_i,
  input  logic             a_vld_i,
  input  logic             b_vld_i,
  input  logic [PHI_W-1:0] a_phi_i,
  input  logic [PHI_W-1:0] b_phi_i,
  input  logic [TH_W-1:0]  a_th_i,
  input  logic [TH_W-1:0]  b_th_i,
  input  logic [PHI_W-1:0] win_phi_i,
  input  logic [TH_W-1:0]  win_th_i,
  output logic             pass_o,
  output logic [PHI_W-1:0] dphi_o
);
  logic [TH_W-1:0] dth;

  always_comb begin
    dphi_o = (a_phi_i > b_phi_i) ? a_phi_i - b_phi_i : b_phi_i - a_phi_i;
    dth    = (a_th_i > b_th_i) ? a_th_i - b_th_i : b_th_i - a_th_i;
    pass_o = allow_i && a_vld_i && b_vld_i && (dphi_o < win_phi_i) && (dth < win_th_i);
  end
endmodule

// File: rtl/best_partner_select.sv
module best_partner_select #(
  parameter int N_PART = 18,
  parameter int PHI_W  = 12,
  parameter int IDX_W  = 5
) (
  input  logic [N_PART-1:0]       pass_i,
  input  logic [N_PART*PHI_W-1:0] dphi_i,
  output logic                    found_o,
  output logic [IDX_W-1:0]        idx_o,
  output logic [PHI_W-1:0]        dphi_o
);
  // strict less-than keeps the lower index on ties
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    dphi_o  = '0;
    for (int p = 0; p < N_PART; p++) begin
      if (pass_i[p] && (!found_o || dphi_i[p*PHI_W +: PHI_W] < dphi_o)) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(p);
        dphi_o  = dphi_i[p*PHI_W +: PHI_W];
      end
    end
  end

  // R3
  pick_passes_chk: assert final (!found_o || pass_i[idx_o]);
endmodule

// File: rtl/station_pair_matcher.sv
module station_pair_matcher
  import pair_match_pkg::*;
#(
  parameter int N_KEY  = 18,
  parameter int N_PART = 18,
  parameter int PHI_W  = 12,
  parameter int TH_W   = 8,
  parameter int SPAN   = 6,
  parameter logic [MASK_MAX-1:0] ALLOW_MASK = band_mask(N_KEY, N_PART, SPAN)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_KEY-1:0]         a_vld_i,
  input  logic [N_KEY*PHI_W-1:0]   a_phi_i,
  input  logic [N_KEY*TH_W-1:0]    a_theta_i,
  input  logic [N_PART-1:0]        b_vld_i,
  input  logic [N_PART*PHI_W-1:0]  b_phi_i,
  input  logic [N_PART*TH_W-1:0]   b_theta_i,
  input  logic [PHI_W-1:0]         win_phi_i,
  input  logic [TH_W-1:0]          win_theta_i,
  output logic [N_KEY-1:0]         match_o,
  output logic [N_KEY*IDX_W-1:0]   idx_o,
  output logic [N_KEY*PHI_W-1:0]   dphi_o
);
  localparam int IDX_W = (N_PART > 1) ? $clog2(N_PART) : 1;

  logic [N_KEY-1:0][N_PART-1:0]       pass;
  logic [N_KEY-1:0][N_PART*PHI_W-1:0] dphi_all;
  logic [N_KEY-1:0]                   found_d;
  logic [N_KEY*IDX_W-1:0]             idx_d;
  logic [N_KEY*PHI_W-1:0]             dphi_d;

  for (genvar k = 0; k < N_KEY; k++) begin : g_key
    for (genvar p = 0; p < N_PART; p++) begin : g_part
      pair_window_cell #(.PHI_W(PHI_W), .TH_W(TH_W)) u_cell (
        .allow_i  (ALLOW_MASK[k*N_PART+p]),
        .a_vld_i  (a_vld_i[k]),
        .b_vld_i  (b_vld_i[p]),
        .a_phi_i  (a_phi_i[k*PHI_W +: PHI_W]),
        .b_phi_i  (b_phi_i[p*PHI_W +: PHI_W]),
        .a_th_i   (a_theta_i[k*TH_W +: TH_W]),
        .b_th_i   (b_theta_i[p*TH_W +: TH_W]),
        .win_phi_i(win_phi_i),
        .win_th_i (win_theta_i),
        .pass_o   (pass[k][p]),
        .dphi_o   (dphi_all[k][p*PHI_W +: PHI_W])
      );
    end

    best_partner_select #(.N_PART(N_PART), .PHI_W(PHI_W), .IDX_W(IDX_W)) u_sel (
      .pass_i (pass[k]),
      .dphi_i (dphi_all[k]),
      .found_o(found_d[k]),
      .idx_o  (idx_d[k*IDX_W +: IDX_W]),
      .dphi_o (dphi_d[k*PHI_W +: PHI_W])
    );

    // R7
    no_match_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !match_o[k] |-> (idx_o[k*IDX_W +: IDX_W] == '0 && dphi_o[k*PHI_W +: PHI_W] == '0));
    // R1
    phi_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_o[k] |-> (dphi_o[k*PHI_W +: PHI_W] < $past(win_phi_i)));
    // R5
    masked_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_o[k] |-> ALLOW_MASK[k*N_PART + int'(idx_o[k*IDX_W +: IDX_W])]);
    // R6
    key_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_o[k] |-> $past(a_vld_i[k]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_o <= '0;
      idx_o   <= '0;
      dphi_o  <= '0;
    end else begin
      match_o <= found_d;
      idx_o   <= idx_d;
      dphi_o  <= dphi_d;
    end
  end
endmodule

// File: tb/station_pair_matcher_test.sv
`timescale 1ns/1ps
module station_pair_matcher_test;
  localparam int NK = 18, NP = 18, PW = 12, TW = 8, IW = 5, SP = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NK-1:0] a_vld, match;
  logic [NK*PW-1:0] a_phi, dphi;
  logic [NK*TW-1:0] a_th;
  logic [NP-1:0] b_vld;
  logic [NP*PW-1:0] b_phi;
  logic [NP*TW-1:0] b_th;
  logic [PW-1:0] win_phi;
  logic [TW-1:0] win_th;
  logic [NK*IW-1:0] idx;

  int total = 0, bad = 0;
  bit exp_m[NK];
  int exp_i[NK], exp_d[NK];

  always #5 clk = ~clk;

  station_pair_matcher uut (
    .clk_i(clk), .rst_ni(rst_n),
    .a_vld_i(a_vld), .a_phi_i(a_phi), .a_theta_i(a_th),
    .b_vld_i(b_vld), .b_phi_i(b_phi), .b_theta_i(b_th),
    .win_phi_i(win_phi), .win_theta_i(win_th),
    .match_o(match), .idx_o(idx), .dphi_o(dphi)
  );

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic model(input int k, output bit m, output int ix, output int d);
    m = 0; ix = 0; d = 0;
    for (int p = 0; p < NP; p++) begin
      int dp, dt;
      dp = iabs(int'(a_phi[k*PW +: PW]) - int'(b_phi[p*PW +: PW]));
      dt = iabs(int'(a_th[k*TW +: TW]) - int'(b_th[p*TW +: TW]));
      if (a_vld[k] && b_vld[p] && iabs(k - p) <= SP && dp < int'(win_phi) && dt < int'(win_th))
        if (!m || dp < d) begin m = 1; ix = p; d = dp; end
    end
  endtask

  task automatic check_key(input int k, input bit m, input int ix, input int d, input string tag);
    total++;
    if (match[k] !== m || int'(idx[k*IW +: IW]) != ix || int'(dphi[k*PW +: PW]) != d) begin
      bad++;
      $display("FAIL %s key%0d: got m=%0b i=%0d d=%0d exp m=%0b i=%0d d=%0d", tag, k,
               match[k], idx[k*IW +: IW], dphi[k*PW +: PW], m, ix, d);
    end
  endtask

  task automatic clear_all();
    a_vld = '0; a_phi = '0; a_th = '0; b_vld = '0; b_phi = '0; b_th = '0;
  endtask
  task automatic set_a(input int k, input int ph, input int th);
    a_vld[k] = 1'b1; a_phi[k*PW +: PW] = PW'(ph); a_th[k*TW +: TW] = TW'(th);
  endtask
  task automatic set_b(input int p, input int ph, input int th);
    b_vld[p] = 1'b1; b_phi[p*PW +: PW] = PW'(ph); b_th[p*TW +: TW] = TW'(th);
  endtask

  // inputs are already driven; checks hold before the edge, then new result after it
  task automatic step(input string tag);
    for (int k = 0; k < NK; k++) check_key(k, exp_m[k], exp_i[k], exp_d[k], "R8 hold");
    for (int k = 0; k < NK; k++) model(k, exp_m[k], exp_i[k], exp_d[k]);
    @(posedge clk); #1;
    for (int k = 0; k < NK; k++) check_key(k, exp_m[k], exp_i[k], exp_d[k], tag);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    clear_all(); win_phi = '0; win_th = '0;
    for (int k = 0; k < NK; k++) begin exp_m[k] = 0; exp_i[k] = 0; exp_d[k] = 0; end
    repeat (3) @(posedge clk);
    #1;
    for (int k = 0; k < NK; k++) check_key(k, 0, 0, 0, "R8 reset");
    @(negedge clk); rst_n = 1'b1;

    // R1: equal to window fails, one below passes
    @(negedge clk); clear_all(); win_phi = 12'd10; win_th = 8'd20;
    set_a(0, 100, 50); set_b(0, 110, 50);
    step("R1");
    check_key(0, 0, 0, 0, "R1 edge/R7");
    @(negedge clk); set_b(1, 91, 50);
    step("R1");
    check_key(0, 1, 1, 9, "R1");

    // R2 and R3: nearer partner fails polar window, farther one passes
    @(negedge clk); clear_all(); win_phi = 12'd50; win_th = 8'd5;
    set_a(3, 400, 60); set_b(2, 401, 65); set_b(4, 403, 56);
    step("R2");
    check_key(3, 1, 4, 3, "R2 R3");

    // R4: tie on azimuth difference
    @(negedge clk); clear_all(); win_phi = 12'd30; win_th = 8'd30;
    set_a(4, 200, 10); set_b(7, 207, 12); set_b(2, 193, 9);
    step("R4");
    check_key(4, 1, 2, 7, "R4");

    // R5: masked partner nearer than allowed one
    @(negedge clk); clear_all(); win_phi = 12'd60; win_th = 8'd30;
    set_a(0, 500, 40); set_b(9, 500, 40); set_b(5, 520, 40);
    step("R5");
    check_key(0, 1, 5, 20, "R5");
    @(negedge clk); b_vld[5] = 1'b0;
    step("R5");
    check_key(0, 0, 0, 0, "R5 R7");

    // R6: invalid partner ignored, invalid key never matches
    @(negedge clk); clear_all(); win_phi = 12'd60; win_th = 8'd30;
    set_a(10, 700, 40); set_b(10, 700, 40); set_b(12, 705, 40); b_vld[10] = 1'b0;
    step("R6");
    check_key(10, 1, 12, 5, "R6");
    @(negedge clk); a_vld[10] = 1'b0;
    step("R6");
    check_key(10, 0, 0, 0, "R6");

    // R9: all keys concurrently, random sets with narrow ranges
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      win_phi = PW'($urandom_range(0, 48));
      win_th  = TW'($urandom_range(0, 12));
      for (int k = 0; k < NK; k++) begin
        a_vld[k] = ($urandom_range(0, 9) < 8);
        a_phi[k*PW +: PW] = PW'($urandom_range(0, 80));
        a_th[k*TW +: TW]  = TW'($urandom_range(0, 24));
      end
      for (int p = 0; p < NP; p++) begin
        b_vld[p] = ($urandom_range(0, 9) < 8);
        b_phi[p*PW +: PW] = PW'($urandom_range(0, 80));
        b_th[p*TW +: TW]  = TW'($urandom_range(0, 24));
      end
      step("R9 R3 R4");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule